// File: doc/BRIEF.md
# Shared Open-Drain Status Line Port

This block sits between local logic and a group of active-low, open-drain status lines that several agents share. Typical groups are a three-bit error severity code and a four-bit event bus. Both use the same logic; only the `WIDTH` parameter changes. For the severity code, bit 0 flags a correctable error, bit 1 a non-correctable error and bit 2 a fatal error. Each of these is asserted by pulling its line low.

On the drive side, a one-cycle local request on a bit turns on that bit's output enable. The pad value is tied low, so enabling a bit pulls the wire down. The enable then stays on for a fixed minimum time.

On the receive side, each raw line value is brought into the clock domain and then glitch-filtered. A filtered assertion sets a sticky flag, but only while the block is not pulling that same line itself. Capture is also held off during a short tail after the block's own drive ends, because the filtered copy of the wire lags the wire. As a result, the flags log only other agents' assertions.

Each flag has its own interrupt enable. An interrupt output is raised while any enabled flag is set, and it is stretched to a minimum pulse width.

Top module: `odl_line_port`

## Requirements
- R1: `line_out` is constant 0 on every bit. Driving is expressed only through `line_oe`, where 1 means the bit is pulled low.
- R2: A `req_assert` bit sampled high at a clock edge sets that bit of `line_oe` from that edge on. The enable stays set until HOLD_CYC (12) edges have passed without a further request on that bit. A single-cycle request therefore gives exactly 12 cycles of drive.
- R3: Each `line_n` bit passes through SYNC_STAGES (2) flip-flops. Its filtered value changes only after FILT_CNT (4) consecutive synchronized samples that differ from the current filtered value. A low pulse lasting 1 to 3 cycles is ignored.
- R4: At an edge, a filtered low on a bit sets the matching `flags` bit only if `line_oe` for that bit is 0 in the cycle before the edge. Capture therefore still works in the very cycle a local request is presented. Capture is blocked while the bit drives and for SYNC_STAGES+FILT_CNT (6) edges after its drive ends.
- R5: `flags` bits are sticky. A `clr_flags` bit clears its flag at the next edge. If a capture happens on the same edge as a clear, the flag stays set.
- R6: `irq` rises one edge after any bit of `flags & irq_enable` becomes 1. It stays high through the cycle IRQ_CYC (6) edges after that term was last seen 1, so every pulse is at least 6 cycles long.
- R7: While `rst` is high at an edge, `line_oe`, `flags` and `irq` all become 0, and the internal filtered values return to the deasserted level (high).
- R8: Every bit's drive timer, filter, capture gate and flag work independently of the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_assert | input | WIDTH | Per-bit local request to pull the line low |
| line_n | input | WIDTH | Raw wire level, active low, may be asynchronous |
| clr_flags | input | WIDTH | Per-bit write-one-to-clear pulse for `flags` |
| irq_enable | input | WIDTH | Per-bit interrupt enable |
| line_oe | output | WIDTH | Per-bit output enable of the open-drain pad |
| line_out | output | WIDTH | Pad output value, tied low |
| flags | output | WIDTH | Sticky log of filtered foreign assertions |
| irq | output | 1 | Stretched interrupt request |

## Verification
Foreign low pulses of one, two, three and four cycles separate a filter that counts consecutive samples from one that reacts early or late. Requests issued while a foreign agent already holds the wire low, and then after it has released, test the capture gate at both of its edges. Self-drive with no foreign activity shows that the block's own echo never reaches the log, including during the tail after drive ends. Clears that collide with a held foreign assertion, interrupt enables toggled around set flags, and a long pseudo-random mix across all bits test clear priority, pulse stretching and independence of the bits.

// File: rtl/odl_pkg.sv
package odl_pkg;

    // width of a counter that must hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // per-bit view handed from the line logic to the capture logic
    typedef struct packed {
        logic seen_low;  // filtered wire is asserted (low)
        logic gate_open; // bit is neither driving nor in its echo tail
    } odl_obs_t;

endpackage

// File: rtl/odl_in_filter.sv
module odl_in_filter
    import odl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CNT    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = cnt_w(FILT_CNT - 1);
    localparam int SW = cnt_w(FILT_CNT);
    localparam logic [CW-1:0] LAST = CW'(FILT_CNT - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   sample;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
    end

    assign sample = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_n <= 1'b1;
        end else if (sample == filt_n) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_n <= sample;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // independent run-length tracker on the synchronized samples
    logic [SW-1:0] streak_q;
    logic          prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            streak_q <= '0;
            prev_q   <= 1'b1;
        end else begin
            prev_q <= sample;
            if (sample != prev_q)              streak_q <= SW'(1);
            else if (streak_q != SW'(FILT_CNT)) streak_q <= streak_q + 1'b1;
        end
    end

    AST_FILT_RUN: assert property (@(posedge clk) disable iff (rst)
        $changed(filt_n) |-> (streak_q >= SW'(FILT_CNT)) && (prev_q == filt_n)); // R3

endmodule

// File: rtl/odl_drive_hold.sv
module odl_drive_hold
    import odl_pkg::*;
#(
    parameter int HOLD_CYC  = 12,
    parameter int BLANK_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic oe,
    output logic gate_open
);
    localparam int HW = cnt_w(HOLD_CYC);
    localparam int BW = cnt_w(BLANK_CYC);

    logic [HW-1:0] hold_q;
    logic [BW-1:0] blank_q;

    always_ff @(posedge clk) begin
        if (rst)                hold_q <= '0;
        else if (req)           hold_q <= HW'(HOLD_CYC);
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    // echo tail: the filtered copy of our own drive lags the wire
    always_ff @(posedge clk) begin
        if (rst)                 blank_q <= '0;
        else if (hold_q != '0)   blank_q <= BW'(BLANK_CYC);
        else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
    end

    assign oe        = (hold_q != '0);
    assign gate_open = (hold_q == '0) && (blank_q == '0);

    // length of the current drive run, counted separately
    logic [HW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                          age_q <= '0;
        else if (!oe)                     age_q <= '0;
        else if (age_q != HW'(HOLD_CYC))  age_q <= age_q + 1'b1;
    end

    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> age_q == HW'(HOLD_CYC)); // R2

    AST_REQ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        req |=> oe); // R2

endmodule

// File: rtl/odl_capture.sv
module odl_capture
    import odl_pkg::*;
#(
    parameter int WIDTH   = 3,
    parameter int IRQ_CYC = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  odl_obs_t            obs [WIDTH],
    input  logic [WIDTH-1:0]    clr,
    input  logic [WIDTH-1:0]    en,
    output logic [WIDTH-1:0]    flags,
    output logic                irq
);
    localparam int IW = cnt_w(IRQ_CYC);

    logic [WIDTH-1:0] set_v;
    logic             pend;
    logic [IW-1:0]    irq_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign set_v[i] = obs[i].seen_low && obs[i].gate_open;

        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[i]) |-> $past(clr[i])); // R5

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> flags[i]); // R5
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set_v;
    end

    assign pend = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst)               irq_q <= '0;
        else if (pend)         irq_q <= IW'(IRQ_CYC);
        else if (irq_q != '0)  irq_q <= irq_q - 1'b1;
    end

    assign irq = (irq_q != '0);

    logic [IW-1:0] irq_age_q;
    always_ff @(posedge clk) begin
        if (rst)                             irq_age_q <= '0;
        else if (!irq)                       irq_age_q <= '0;
        else if (irq_age_q != IW'(IRQ_CYC))  irq_age_q <= irq_age_q + 1'b1;
    end

    AST_IRQ_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> irq_age_q == IW'(IRQ_CYC)); // R6

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        pend |=> irq); // R6

endmodule

// File: rtl/odl_line_port.sv
module odl_line_port
    import odl_pkg::*;
#(
    parameter int WIDTH       = 3,
    parameter int HOLD_CYC    = 12,
    parameter int FILT_CNT    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_CYC     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_assert,
    input  logic [WIDTH-1:0] line_n,
    input  logic [WIDTH-1:0] clr_flags,
    input  logic [WIDTH-1:0] irq_enable,
    output logic [WIDTH-1:0] line_oe,
    output logic [WIDTH-1:0] line_out,
    output logic [WIDTH-1:0] flags,
    output logic             irq
);
    localparam int BLANK_CYC = SYNC_STAGES + FILT_CNT;

    odl_obs_t         obs [WIDTH];
    logic [WIDTH-1:0] filt_n;
    logic [WIDTH-1:0] gate_open;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        odl_in_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CNT    (FILT_CNT)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_n  (line_n[i]),
            .filt_n (filt_n[i])
        );

        odl_drive_hold #(
            .HOLD_CYC  (HOLD_CYC),
            .BLANK_CYC (BLANK_CYC)
        ) u_hold (
            .clk       (clk),
            .rst       (rst),
            .req       (req_assert[i]),
            .oe        (line_oe[i]),
            .gate_open (gate_open[i])
        );

        assign obs[i].seen_low  = ~filt_n[i];
        assign obs[i].gate_open = gate_open[i];

        AST_NO_SELF_LOG: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[i]) |-> !$past(line_oe[i])); // R4
    end

    assign line_out = '0;

    odl_capture #(
        .WIDTH   (WIDTH),
        .IRQ_CYC (IRQ_CYC)
    ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .obs   (obs),
        .clr   (clr_flags),
        .en    (irq_enable),
        .flags (flags),
        .irq   (irq)
    );

endmodule

// File: tb/odl_line_port_bench.sv
module odl_line_port_bench;
    localparam int W     = 3;
    localparam int HOLD  = 12;
    localparam int FILT  = 4;
    localparam int BLANK = 6;
    localparam int IRQC  = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] req_assert = '0;
    logic [W-1:0] ext_low = '0;
    logic [W-1:0] clr_flags = '0;
    logic [W-1:0] irq_enable = '0;
    logic [W-1:0] line_n;
    logic [W-1:0] line_oe;
    logic [W-1:0] line_out;
    logic [W-1:0] flags;
    logic         irq;

    // wired-AND of this block's drive and the foreign agents
    assign line_n = ~(line_oe | ext_low);

    always #10 clk = ~clk;

    odl_line_port u_odl_line_port (
        .clk        (clk),
        .rst        (rst),
        .req_assert (req_assert),
        .line_n     (line_n),
        .clr_flags  (clr_flags),
        .irq_enable (irq_enable),
        .line_oe    (line_oe),
        .line_out   (line_out),
        .flags      (flags),
        .irq        (irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag_f = "R7";  // requirement the current phase targets for flags

    // behavioural reference model
    bit m_s1 [W];
    bit m_s2 [W];
    bit m_filt [W];
    int m_run [W];
    int m_hold [W];
    int m_blank [W];
    bit m_flag [W];
    int m_irq;

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < W; b++) begin
                m_s1[b] = 1; m_s2[b] = 1; m_filt[b] = 1; m_run[b] = 0;
                m_hold[b] = 0; m_blank[b] = 0; m_flag[b] = 0;
            end
            m_irq = 0;
        end else begin
            bit pend;
            pend = 0;
            for (int b = 0; b < W; b++) if (m_flag[b] && irq_enable[b]) pend = 1;
            if (pend) m_irq = IRQC; else if (m_irq > 0) m_irq--;
            for (int b = 0; b < W; b++) begin
                bit setb;
                setb = (m_hold[b] == 0) && (m_blank[b] == 0) && (m_filt[b] == 0);
                if (setb) m_flag[b] = 1; else if (clr_flags[b]) m_flag[b] = 0;
                if (m_hold[b] != 0) m_blank[b] = BLANK; else if (m_blank[b] > 0) m_blank[b]--;
                if (req_assert[b]) m_hold[b] = HOLD; else if (m_hold[b] > 0) m_hold[b]--;
                if (m_s2[b] == m_filt[b]) m_run[b] = 0;
                else if (m_run[b] == FILT - 1) begin m_filt[b] = m_s2[b]; m_run[b] = 0; end
                else m_run[b]++;
                m_s2[b] = m_s1[b];
                m_s1[b] = line_n[b];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [W-1:0] e_oe, e_fl;
        for (int b = 0; b < W; b++) begin
            e_oe[b] = (m_hold[b] != 0);
            e_fl[b] = m_flag[b];
        end
        chk("R1 line_out", 32'(line_out), 32'd0);
        chk("R2 line_oe", 32'(line_oe), 32'(e_oe));
        chk({tag_f, " flags"}, 32'(flags), 32'(e_fl));
        chk("R6 irq", 32'(irq), 32'(m_irq != 0));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [W-1:0] m);
        req_assert = m; cyc(1); req_assert = '0;
    endtask

    task automatic pulse_clr(input logic [W-1:0] m);
        clr_flags = m; cyc(1); clr_flags = '0;
    endtask

    task automatic foreign(input logic [W-1:0] m, input int len);
        ext_low = m; cyc(len); ext_low = '0;
    endtask

    bit done = 0;

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state observed at the ports
        tag_f = "R7";
        chk("R7 oe after reset", 32'(line_oe), 32'd0);
        chk("R7 flags after reset", 32'(flags), 32'd0);
        chk("R7 irq after reset", 32'(irq), 32'd0);

        // R3: glitches of 1..3 cycles ignored, 4 cycles captured
        tag_f = "R3";
        for (int len = 1; len <= 3; len++) begin
            foreign(3'b001, len); cyc(10);
            chk("R3 short glitch ignored", 32'(flags[0]), 32'd0);
        end
        foreign(3'b001, 4); cyc(10);
        chk("R3 four-cycle assertion logged", 32'(flags[0]), 32'd1);

        // R5: clear, and clear colliding with a held assertion
        tag_f = "R5";
        pulse_clr(3'b001); cyc(1);
        chk("R5 clear", 32'(flags[0]), 32'd0);
        ext_low = 3'b010; cyc(10);
        pulse_clr(3'b010); cyc(1);
        chk("R5 set wins over clear", 32'(flags[1]), 32'd1);
        ext_low = '0; cyc(8);
        pulse_clr(3'b010); cyc(1);
        chk("R5 clear after release", 32'(flags[1]), 32'd0);

        // R2/R4: own drive never logged, including the echo tail
        tag_f = "R4";
        pulse_req(3'b100);
        chk("R2 drive starts", 32'(line_oe[2]), 32'd1);
        cyc(30);
        chk("R4 own drive not logged", 32'(flags[2]), 32'd0);
        // R2: repeated request extends the drive
        pulse_req(3'b100); cyc(6); pulse_req(3'b100); cyc(10);
        chk("R2 drive extended", 32'(line_oe[2]), 32'd1);
        cyc(20);

        // R4: foreign assertion already filtered when request arrives
        ext_low = 3'b001; cyc(8);
        pulse_req(3'b001); ext_low = '0; cyc(1);
        chk("R4 capture in request cycle", 32'(flags[0]), 32'd1);
        pulse_clr(3'b001);
        // R4: foreign assertion only while driving is missed
        pulse_req(3'b001); foreign(3'b001, 6); cyc(25);
        chk("R4 foreign during drive masked", 32'(flags[0]), 32'd0);

        // R6: interrupt stretch
        tag_f = "R6";
        irq_enable = 3'b010;
        foreign(3'b001, 5); cyc(12);
        chk("R6 disabled flag no irq", 32'(irq), 32'd0);
        irq_enable = 3'b001; cyc(2);
        chk("R6 enabled flag irq", 32'(irq), 32'd1);
        irq_enable = '0; cyc(3);
        chk("R6 stretch holds", 32'(irq), 32'd1);
        cyc(5);
        chk("R6 stretch ends", 32'(irq), 32'd0);
        pulse_clr(3'b111);

        // R8: mixed pseudo-random activity on all bits
        tag_f = "R8";
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            for (int b = 0; b < W; b++) begin
                if (r[b*4 +: 3] == 3'd0) ext_low[b] = ~ext_low[b];
                req_assert[b] = (r[16 + b*3 +: 3] == 3'd0) && (r[28] == 1'b0);
            end
            clr_flags  = (r[30:29] == 2'd0) ? r[2:0] : '0;
            irq_enable = (r[31]) ? r[14:12] : irq_enable;
            cyc(1);
        end
        req_assert = '0; ext_low = '0; clr_flags = '0;
        cyc(40);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule